// File: doc/BRIEF.md
# Video Memory Byte-Stream Write Port

This block lets a host processor fill a 64 KB video memory, organised as 16-bit words, through a handful of byte-wide registers. The host first writes a control register that sets the stride and picks which half of the word moves the pointer. It then loads a word address in two byte writes and streams bytes through a low-half data register and a high-half data register. Each data write becomes a single byte write on the memory side: a byte address, a byte of data and a strobe.

Internally the block keeps a byte pointer equal to twice the word address. Low-half writes land on the pointer and high-half writes land on the pointer plus one. After a write to the selected half, the pointer advances by 2, 64, 128 or 256 bytes and wraps within the 64 KB space. This lets the host fill rows or columns of a tile map with no further address writes. The memory returns the current contents at the write address, and the block flags whether the write really changes the stored byte. Loading the address also arms a flag telling the read side that its next data-port read is a discard read.

Top module: `vram_write_port`

## Requirements
- R1: Register select codes on `regSel` are 0 control, 1 word address low byte, 2 word address high byte, 3 low-half data, 4 high-half data. A write with a select of 5, 6 or 7 changes nothing and produces no memory strobe.
- R2: Control register bits [1:0] set the stride in bytes: 0 gives 2, 1 gives 64, 2 gives 128, 3 gives 256. Control bit 7 chooses the stepping half: 0 for the low-half write, 1 for the high-half write.
- R3: Each address byte write takes effect immediately. The byte pointer becomes twice the 16-bit word address {high byte, low byte}, modulo 65536, so it is always even.
- R4: With control bit 7 at 0, a low-half data write advances the pointer by the stride, and a high-half data write leaves the pointer unchanged.
- R5: With control bit 7 at 1, a high-half data write advances the pointer by the stride, and a low-half data write leaves the pointer unchanged.
- R6: A low-half data write drives `memWrEn` high for exactly one cycle, in the cycle after the host write, with `memAddr` equal to the pointer before the write and `memWrData` equal to the written byte. A high-half data write does the same at the pointer plus one.
- R7: The pointer advance wraps modulo 65536.
- R8: `memChanged` is high only while `memWrEn` is high and `memRdData` differs from `memWrData`.
- R9: `dummyReadPending` becomes 1 in the cycle after any address byte write. It returns to 0 in the cycle after a data-port read, which is `regRdEn` with select 3 or 4.
- R10: After reset the pointer is 0, the stride is 2, stepping is on the low-half write, and `memWrEn` and `dummyReadPending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regRdEn | input | 1 | Host register read strobe |
| regSel | input | 3 | Host register select |
| regWrData | input | 8 | Host write byte |
| memRdData | input | 8 | Current memory byte at `memAddr` |
| memWrEn | output | 1 | Byte write strobe to memory |
| memAddr | output | 16 | Byte address to memory |
| memWrData | output | 8 | Byte to write |
| memChanged | output | 1 | Write would alter the stored byte |
| dummyReadPending | output | 1 | Next data-port read is a discard read |

## Verification
The assertions assume that the host never raises `regWrEn` and `regRdEn` in the same cycle. They also assume that `memRdData` is a combinational function of `memAddr`, and that no writer other than this block touches the memory. The bench's memory model reads combinationally and writes only when `memWrEn` and `memChanged` are both high. The random host operations issue exactly one strobe per operation, separated by idle cycles, so these assumptions always hold.

// File: rtl/vwp_pkg.sv
package vwp_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ADDRLO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDRHI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DATALO = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATAHI = 3'd4;

  typedef struct packed {
    logic ldCtrl;
    logic ldAddrLo;
    logic ldAddrHi;
    logic wrLo;
    logic wrHi;
    logic rdPort;
  } vwpStrobes_t;
endpackage

// File: rtl/vwp_ctrl.sv
module vwp_ctrl
  import vwp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [SEL_W-1:0] regSel,
  output vwpStrobes_t      strobes
);
  always_comb begin
    strobes          = '0;
    strobes.ldCtrl   = regWrEn && (regSel == SEL_CTRL);
    strobes.ldAddrLo = regWrEn && (regSel == SEL_ADDRLO);
    strobes.ldAddrHi = regWrEn && (regSel == SEL_ADDRHI);
    strobes.wrLo     = regWrEn && (regSel == SEL_DATALO);
    strobes.wrHi     = regWrEn && (regSel == SEL_DATAHI);
    strobes.rdPort   = regRdEn && ((regSel == SEL_DATALO) || (regSel == SEL_DATAHI));
  end

  // R1: at most one register is loaded per host write
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.ldCtrl, strobes.ldAddrLo, strobes.ldAddrHi, strobes.wrLo, strobes.wrHi}));
endmodule

// File: rtl/vwp_datapath.sv
module vwp_datapath
  import vwp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  vwpStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrByte,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              dummyReadPending
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [1:0]        stepCode;
  logic              stepHigh;
  logic [DATA_W-1:0] addrLo;
  logic [HI_W-1:0]   addrHi;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] stepSize;
  logic [ADDR_W-1:0] wordFromLo;
  logic [ADDR_W-1:0] wordFromHi;

  function automatic logic [ADDR_W-1:0] strideOf(input logic [1:0] code);
    if (code == 2'd0) return ADDR_W'(2);
    return ADDR_W'(32) << code;
  endfunction

  assign stepSize   = strideOf(stepCode);
  assign wordFromLo = {addrHi, wrByte};
  assign wordFromHi = {wrByte[HI_W-1:0], addrLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCode         <= 2'd0;
      stepHigh         <= 1'b0;
      addrLo           <= '0;
      addrHi           <= '0;
      ptr              <= '0;
      memWrEn          <= 1'b0;
      memAddr          <= '0;
      memWrData        <= '0;
      dummyReadPending <= 1'b0;
    end else begin
      memWrEn <= 1'b0;
      if (strobes.ldCtrl) begin
        stepCode <= wrByte[1:0];
        stepHigh <= wrByte[7];
      end
      if (strobes.ldAddrLo) begin
        addrLo <= wrByte;
        ptr    <= wordFromLo << 1;
      end
      if (strobes.ldAddrHi) begin
        addrHi <= wrByte[HI_W-1:0];
        ptr    <= wordFromHi << 1;
      end
      if (strobes.wrLo) begin
        memWrEn   <= 1'b1;
        memAddr   <= ptr;
        memWrData <= wrByte;
        if (!stepHigh) ptr <= ptr + stepSize;
      end
      if (strobes.wrHi) begin
        memWrEn   <= 1'b1;
        memAddr   <= ptr + ADDR_W'(1);
        memWrData <= wrByte;
        if (stepHigh) ptr <= ptr + stepSize;
      end
      if (strobes.ldAddrLo || strobes.ldAddrHi) dummyReadPending <= 1'b1;
      else if (strobes.rdPort)                  dummyReadPending <= 1'b0;
    end
  end

  // R3: pointer stays word aligned
  p_ptr_even_r3: assert property (@(posedge clk) disable iff (!rstN) ptr[0] == 1'b0);
  // R4, R7: low-half stepping with wrap
  p_step_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLo && !stepHigh) |=> ptr == $past(ptr) + $past(stepSize));
  p_hold_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrHi && !stepHigh) |=> $stable(ptr));
  // R5: high-half stepping
  p_step_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrHi && stepHigh) |=> ptr == $past(ptr) + $past(stepSize));
  p_hold_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLo && stepHigh) |=> $stable(ptr));
  // R6: high-half writes land on odd addresses
  p_hi_odd_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHi |=> (memWrEn && memAddr[0]));
  // R9: address load arms the discard-read flag
  p_dummy_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldAddrLo || strobes.ldAddrHi) |=> dummyReadPending);
endmodule

// File: rtl/vram_write_port.sv
module vram_write_port
  import vwp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              memChanged,
  output logic              dummyReadPending
);
  vwpStrobes_t strobes;

  vwp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regSel  (regSel),
    .strobes (strobes)
  );

  vwp_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobes          (strobes),
    .wrByte           (regWrData),
    .memWrEn          (memWrEn),
    .memAddr          (memAddr),
    .memWrData        (memWrData),
    .dummyReadPending (dummyReadPending)
  );

  assign memChanged = memWrEn && (memRdData != memWrData);

  // R8: change flag never without a strobe
  p_change_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    memChanged |-> memWrEn);
endmodule

// File: tb/tb_vram_write_port.sv
`timescale 1ns/100ps
module tb_vram_write_port;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  memRdData;
  logic        memWrEn, memChanged, dummyReadPending;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vram_write_port dut (.*);

  // Bench memory model, aliased onto 1024 bytes
  logic [7:0] vmem [1024];
  assign memRdData = vmem[memAddr[9:0]];
  always @(posedge clk) if (memWrEn && memChanged) vmem[memAddr[9:0]] <= memWrData;

  // Reference state
  logic [1:0]  mCode;
  bit          mHigh, mDummy;
  logic [7:0]  mLo, mHi;
  logic [15:0] mPtr;

  function automatic logic [15:0] strideRef(input logic [1:0] c);
    case (c)
      2'd0: return 16'd2;
      2'd1: return 16'd64;
      2'd2: return 16'd128;
      default: return 16'd256;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One host operation, then check outputs one edge later
  task automatic hostOp(input logic [2:0] sel, input logic [7:0] d, input bit isRead);
    logic [15:0] expAddr;
    bit dataWr, expChg;
    @(negedge clk);
    regSel = sel; regWrData = d;
    regWrEn = !isRead; regRdEn = isRead;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    dataWr = !isRead && (sel == 3'd3 || sel == 3'd4);
    if (dataWr) begin
      expAddr = (sel == 3'd4) ? mPtr + 16'd1 : mPtr;
      expChg  = vmem[expAddr[9:0]] != d;
      chk(memWrEn === 1'b1, "R6 strobe", memWrEn, 1);
      chk(memAddr === expAddr, "R6 address", memAddr, expAddr);
      chk(memWrData === d, "R6 data", memWrData, d);
      chk(memChanged === expChg, "R8 change", memChanged, expChg);
      if ((sel == 3'd3 && !mHigh) || (sel == 3'd4 && mHigh)) mPtr = mPtr + strideRef(mCode);
    end else begin
      chk(memWrEn === 1'b0, "R1 no strobe", memWrEn, 0);
      chk(memChanged === 1'b0, "R8 idle", memChanged, 0);
      if (!isRead) begin
        case (sel)
          3'd0: begin mCode = d[1:0]; mHigh = d[7]; end
          3'd1: begin mLo = d; mPtr = {mHi, mLo} << 1; mDummy = 1'b1; end
          3'd2: begin mHi = d; mPtr = {mHi, mLo} << 1; mDummy = 1'b1; end
          default: ;
        endcase
      end else if (sel == 3'd3 || sel == 3'd4) mDummy = 1'b0;
    end
    chk(dummyReadPending === mDummy, "R9 dummy flag", dummyReadPending, mDummy);
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 1024; i++) vmem[i] = 8'h00;
    mCode = 0; mHigh = 0; mDummy = 0; mLo = 0; mHi = 0; mPtr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(memWrEn === 1'b0, "R10 strobe low", memWrEn, 0);
    chk(dummyReadPending === 1'b0, "R10 dummy low", dummyReadPending, 0);
    hostOp(3'd3, 8'hA1, 0);   // R10 pointer 0
    hostOp(3'd3, 8'hA2, 0);   // R10 stride 2, low stepping
    hostOp(3'd4, 8'hB2, 0);   // R4 high does not step
    hostOp(3'd3, 8'hA3, 0);
    // R1 ignored selects
    hostOp(3'd5, 8'hFF, 0);
    hostOp(3'd7, 8'h83, 0);
    hostOp(3'd3, 8'hA4, 0);
    // R2 each stride code, R3 address load
    for (int c = 1; c < 4; c++) begin
      hostOp(3'd0, 8'(c), 0);
      hostOp(3'd1, 8'h10, 0);
      hostOp(3'd2, 8'h01, 0);
      hostOp(3'd3, 8'h11, 0);
      hostOp(3'd3, 8'h12, 0);
    end
    // R9 clear by data read
    hostOp(3'd3, 8'h00, 1);
    // R5 high-half stepping, R7 wrap at the top
    hostOp(3'd0, 8'h83, 0);
    hostOp(3'd1, 8'hFF, 0);
    hostOp(3'd2, 8'h7F, 0);
    hostOp(3'd3, 8'h55, 0);
    hostOp(3'd4, 8'h66, 0);
    hostOp(3'd4, 8'h77, 0);
    // R8 same value twice at one address (low write does not step here)
    hostOp(3'd3, 8'h5A, 0);
    hostOp(3'd3, 8'h5A, 0);
    hostOp(3'd4, 8'h00, 1);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] d;
      op = $urandom % 12;
      d  = 8'($urandom);
      case (op)
        0:       hostOp(3'd0, d, 0);
        1:       hostOp(3'd1, d, 0);
        2:       hostOp(3'd2, d, 0);
        3, 4, 5: hostOp(3'd3, d & 8'h0F, 0);
        6, 7:    hostOp(3'd4, d & 8'h0F, 0);
        8:       hostOp(3'(5 + ($urandom % 3)), d, 0);
        9:       hostOp(3'(3 + ($urandom % 2)), d, 1);
        10:      hostOp(3'($urandom % 8), d, 1);
        default: @(negedge clk);
      endcase
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule